// File: doc/BRIEF.md
# Oversampled serial receiver with character FIFO

This block turns an asynchronous serial line into stored characters. A strobe from an external baud generator arrives sixteen times per bit. The receiver times each bit from the falling edge of its start bit and samples it once, near the middle. It assembles characters of five to eight data bits, least significant bit first. It can check an optional parity bit and the first stop bit. A line held low for a whole frame is reported as a break.

Each finished character is stored with three flags: parity error, framing error and break. In queue mode the store is a 16-entry first-in first-out buffer. In single mode it is one holding register. The entry at the head is always shown on the outputs and is removed by a one-cycle pop strobe. The block raises a fill-level request at a selectable threshold and a character-timeout request when data lies unread. It flags overrun when a character arrives with no room. A receiver enable input acts as a local reset: it clears the buffer and the frame state machine but leaves all configuration inputs untouched.

The frame state machine has six states. IDLE goes to START when the synchronised line is low. START goes to DATA when the mid-bit sample is low, or back to IDLE when it is high (false start). DATA goes to PARITY after the last data bit when parity is enabled, and to STOP otherwise. PARITY goes to STOP after its sample. STOP goes to IDLE, or to BRKWAIT when every sample of the frame, the stop bit included, was low. BRKWAIT goes to IDLE once the line is high again. Every state goes to IDLE while the receiver enable is low.

Top module: `serial_rx_core`

## Requirements
- R1: After rst_n, fill is 0, data_ready, overrun, irq_trig and irq_timeout are 0, and rd_data and all three head flags read 0.
- R2: Each bit is sampled once, on the 8th tick16 strobe of its 16, counted from detection of the start edge. A start bit that reads high at its sample is dropped and stores nothing.
- R3: word_len selects 5, 6, 7 or 8 data bits (values 0 to 3). The bits arrive least significant first, and unused upper bits of rd_data read 0.
- R4: With par_en=1, one parity bit follows the data. par_even=1 expects an even count of ones over data and parity, and par_even=0 expects an odd count. A mismatch sets err_parity for that entry.
- R5: A stop bit sampled low sets err_frame for that entry.
- R6: When data, parity and stop samples are all low, a single entry is stored with data 0, err_break=1, err_frame=1 and err_parity=0. Nothing more is stored until the line has returned high.
- R7: fifo_en=1 gives a capacity of 16 entries and fifo_en=0 gives a capacity of 1. Entries leave in arrival order. rd_data and the flags belong to the head entry, pop removes it, fill is the count, and data_ready is high while fill is not 0.
- R8: A character that completes with the store full is discarded and sets overrun. A pop in that same cycle makes room first, so the character is kept. lsr_rd clears overrun, but a new overrun in the same cycle wins.
- R9: With fifo_en=1, irq_trig is high while fill is at least the level set by trig_sel (0:1, 1:4, 2:8, 3:14). With fifo_en=0, irq_trig is high while the holding register is full.
- R10: With fifo_en=1 and fill not 0, a timer counts tick16 strobes since the last arrival or pop. irq_timeout rises once the count exceeds four character times, where one character is (2 + data bits + parity bit) × 16 strobes. An arrival, a pop or an empty store clears it.
- R11: With fifo_en=0, irq_timeout stays 0.
- R12: rx_en=0 empties the store, clears overrun and the timer, and returns the frame state machine to IDLE. Configuration inputs keep their values, and reception resumes correctly once rx_en returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; 0 holds the receiver in local reset |
| tick16 | input | 1 | Oversampling strobe, 16 per bit |
| rxd | input | 1 | Asynchronous serial input, idle high |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| trig_sel | input | 2 | Fill threshold select for irq_trig |
| pop | input | 1 | Remove the head entry |
| lsr_rd | input | 1 | Status read strobe; clears overrun |
| rd_data | output | 8 | Head entry data |
| err_parity | output | 1 | Head entry parity error |
| err_frame | output | 1 | Head entry framing error |
| err_break | output | 1 | Head entry break flag |
| data_ready | output | 1 | At least one unread entry |
| overrun | output | 1 | A character was lost |
| irq_trig | output | 1 | Fill-level request |
| irq_timeout | output | 1 | Character-timeout request |
| fill | output | 5 | Number of stored entries |

## Verification
The completion of a character, when the stop bit is sampled, can fall in the same clock cycle as a pop from the consumer or as an lsr_rd strobe. The bench first times one frame from its first low bit to the rise of data_ready. In single mode with the holding register already full, it then places a pop, and later an lsr_rd, exactly on that completion edge. The pop case passes when the new character replaces the old one with no overrun. The lsr_rd case passes when overrun is still set afterwards and the stored character is unchanged.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BRKWAIT
    } rx_state_t;

    // fill threshold chosen by the 2-bit select
    function automatic int trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       tick,
    input  logic       rxs,
    input  logic [1:0] word_len,
    input  logic       par_en,
    input  logic       par_even,
    output logic       push,
    output rx_entry_t  push_entry
);
    localparam int            CW   = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_t     state, state_nx;
    logic [CW-1:0] os_cnt;
    logic [2:0]    bit_idx;
    logic [2:0]    last_idx;
    logic [7:0]    shreg;
    logic          all_zero;
    logic          par_acc;
    logic          sample;
    logic          brk_now;

    assign last_idx = 3'd4 + 3'(word_len);
    assign brk_now  = all_zero & ~rxs;

    always_comb begin
        sample = 1'b0;
        if (tick) begin
            if (state == ST_START)
                sample = (os_cnt == MID);
            else if (state == ST_DATA || state == ST_PARITY || state == ST_STOP)
                sample = (os_cnt == LAST);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (!rx_en)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (!rxs) state_nx = ST_START;
            ST_START:   if (sample) state_nx = rxs ? ST_IDLE : ST_DATA;
            ST_DATA:    if (sample && bit_idx == last_idx)
                            state_nx = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY:  if (sample) state_nx = ST_STOP;
            ST_STOP:    if (sample) state_nx = brk_now ? ST_BRKWAIT : ST_IDLE;
            ST_BRKWAIT: if (rxs) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt     <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            all_zero   <= 1'b0;
            par_acc    <= 1'b0;
            push       <= 1'b0;
            push_entry <= '0;
        end else if (!rx_en) begin
            os_cnt <= '0;
            push   <= 1'b0;
        end else begin
            push <= 1'b0;
            if (state == ST_IDLE || state == ST_BRKWAIT)
                os_cnt <= '0;
            else if (tick)
                os_cnt <= sample ? '0 : os_cnt + CW'(1);

            if (sample) begin
                case (state)
                    ST_START: begin
                        shreg    <= '0;
                        bit_idx  <= '0;
                        all_zero <= 1'b1;
                        par_acc  <= 1'b0;
                    end
                    ST_DATA: begin
                        shreg[bit_idx] <= rxs;
                        bit_idx        <= bit_idx + 3'd1;
                        all_zero       <= all_zero & ~rxs;
                        par_acc        <= par_acc ^ rxs;
                    end
                    ST_PARITY: begin
                        all_zero <= all_zero & ~rxs;
                        par_acc  <= par_acc ^ rxs;
                    end
                    ST_STOP: begin
                        push            <= 1'b1;
                        push_entry.brk  <= brk_now;
                        push_entry.ferr <= ~rxs;
                        push_entry.perr <= ~brk_now & par_en & (par_acc ^ ~par_even);
                        push_entry.data <= brk_now ? 8'h00 : shreg;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_en,
    input  logic                        fifo_en,
    input  logic                        push,
    input  rx_entry_t                   wr_entry,
    input  logic                        pop,
    input  logic                        lsr_rd,
    output rx_entry_t                   head,
    output logic [$clog2(DEPTH+1)-1:0]  fill,
    output logic                        overrun
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t     mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] cap;
    logic          do_pop, do_push, room;

    assign cap     = fifo_en ? CW'(DEPTH) : CW'(1);
    assign do_pop  = pop && (fill != '0);
    assign room    = (fill < cap) || do_pop;
    assign do_push = push && room;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wptr] <= wr_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else if (!rx_en) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (!rx_en)
            overrun <= 1'b0;
        else if (push && !room)
            overrun <= 1'b1;
        else if (lsr_rd)
            overrun <= 1'b0;
    end

    assign head = (fill != '0) ? mem[rptr] : '0;

endmodule

// File: rtl/serial_rx_timeout.sv
module serial_rx_timeout #(
    parameter int OVS   = 16,
    parameter int CHARS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       fifo_en,
    input  logic       tick,
    input  logic       push,
    input  logic       pop,
    input  logic       empty,
    input  logic [1:0] word_len,
    input  logic       par_en,
    output logic       irq
);
    localparam int MAX_BITS  = 2 + 8 + 1;
    localparam int MAX_LIMIT = CHARS * MAX_BITS * OVS;
    localparam int TW        = $clog2(MAX_LIMIT + 2);

    logic [TW-1:0] cnt;
    logic [TW-1:0] limit;

    assign limit = TW'(CHARS * (7 + int'(word_len) + int'(par_en)) * OVS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!rx_en || !fifo_en || empty || push || pop)
            cnt <= '0;
        else if (tick && cnt <= limit)
            cnt <= cnt + TW'(1);
    end

    assign irq = (cnt > limit);

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OVS   = 16,
    parameter int CHARS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_en,
    input  logic                        tick16,
    input  logic                        rxd,
    input  logic [1:0]                  word_len,
    input  logic                        par_en,
    input  logic                        par_even,
    input  logic                        fifo_en,
    input  logic [1:0]                  trig_sel,
    input  logic                        pop,
    input  logic                        lsr_rd,
    output logic [7:0]                  rd_data,
    output logic                        err_parity,
    output logic                        err_frame,
    output logic                        err_break,
    output logic                        data_ready,
    output logic                        overrun,
    output logic                        irq_trig,
    output logic                        irq_timeout,
    output logic [$clog2(DEPTH+1)-1:0]  fill
);
    logic      rx_meta, rx_sync;
    logic      push;
    rx_entry_t push_entry;
    rx_entry_t head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_sync <= 1'b1;
        end else begin
            rx_meta <= rxd;
            rx_sync <= rx_meta;
        end
    end

    serial_rx_frame #(.OVS(OVS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .tick       (tick16),
        .rxs        (rx_sync),
        .word_len   (word_len),
        .par_en     (par_en),
        .par_even   (par_even),
        .push       (push),
        .push_entry (push_entry)
    );

    serial_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .fifo_en  (fifo_en),
        .push     (push),
        .wr_entry (push_entry),
        .pop      (pop),
        .lsr_rd   (lsr_rd),
        .head     (head),
        .fill     (fill),
        .overrun  (overrun)
    );

    serial_rx_timeout #(.OVS(OVS), .CHARS(CHARS)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .fifo_en  (fifo_en),
        .tick     (tick16),
        .push     (push),
        .pop      (pop),
        .empty    (fill == '0),
        .word_len (word_len),
        .par_en   (par_en),
        .irq      (irq_timeout)
    );

    assign rd_data    = head.data;
    assign err_parity = head.perr;
    assign err_frame  = head.ferr;
    assign err_break  = head.brk;
    assign data_ready = (fill != '0);
    assign irq_trig   = fifo_en ? (int'(fill) >= trig_level(trig_sel)) : (fill != '0);

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
    parameter int DEPTH = 16,
    parameter int FW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          fifo_en,
    input logic          lsr_rd,
    input logic [FW-1:0] fill,
    input logic          overrun,
    input logic          irq_trig,
    input logic          irq_timeout
);
    a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(DEPTH));

    a_r7_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && fill <= FW'(1)) |=> (fifo_en || fill <= FW'(1)));

    a_r7_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |=> (!rx_en || ((fill <= $past(fill) + FW'(1)) && (fill + FW'(1) >= $past(fill)))));

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !lsr_rd && rx_en) |=> (overrun || !rx_en));

    a_r9_trig_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        irq_trig |-> (fill != '0));

    a_r10_timeout_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        irq_timeout |-> (fill != '0));

    a_r11_no_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> !irq_timeout);

    a_r12_local_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (fill == '0 && !overrun && !irq_timeout));

endmodule

bind serial_rx_core serial_rx_chk #(.DEPTH(DEPTH), .FW($clog2(DEPTH+1))) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .fifo_en     (fifo_en),
    .lsr_rd      (lsr_rd),
    .fill        (fill),
    .overrun     (overrun),
    .irq_trig    (irq_trig),
    .irq_timeout (irq_timeout)
);

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b1;
    logic       tick16 = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] word_len = 2'd3;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       fifo_en = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       pop = 1'b0;
    logic       lsr_rd = 1'b0;
    logic [7:0] rd_data;
    logic       err_parity, err_frame, err_break;
    logic       data_ready, overrun, irq_trig, irq_timeout;
    logic [4:0] fill;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int tick_div = 1;
    int ph = 0;
    int cyc = 0;
    int dr_rise = 0;
    logic dr_q = 1'b0;

    serial_rx_core u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick16(tick16), .rxd(rxd),
        .word_len(word_len), .par_en(par_en), .par_even(par_even),
        .fifo_en(fifo_en), .trig_sel(trig_sel), .pop(pop), .lsr_rd(lsr_rd),
        .rd_data(rd_data), .err_parity(err_parity), .err_frame(err_frame),
        .err_break(err_break), .data_ready(data_ready), .overrun(overrun),
        .irq_trig(irq_trig), .irq_timeout(irq_timeout), .fill(fill)
    );

    always #(CLK_NS / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        tick16 = (ph == 0);
        ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
        if (data_ready && !dr_q) dr_rise = cyc;
        dr_q = data_ready;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input int nb);
        return 8'hFF >> (8 - nb);
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input int nb, input bit even);
        return (^(d & mask_of(nb))) ^ !even;
    endfunction

    function automatic logic [10:0] exp_entry(input logic [7:0] d, input int nb,
                                              input bit pen, input bit flip, input bit stop_ok);
        return {1'b0, !stop_ok, pen && flip, d & mask_of(nb)};
    endfunction

    function automatic logic [10:0] head_now();
        return {err_break, err_frame, err_parity, rd_data};
    endfunction

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive_bit(input logic v, input bit glitch);
        for (int i = 0; i < 16 * tick_div; i++) begin
            rxd = (glitch && (i < 4 || i >= 12)) ? ~v : v;
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit pen, input bit peven,
                              input bit flip, input bit stop_ok, input bit glitch);
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i], glitch);
        if (pen) drive_bit(par_bit(d, nb, peven) ^ flip, glitch);
        if (stop_ok) begin
            drive_bit(1'b1, 1'b0);
        end else begin
            rxd = 1'b0;
            wait_cyc(10 * tick_div);
            rxd = 1'b1;
            wait_cyc(6 * tick_div);
        end
        drive_bit(1'b1, 1'b0);
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic send8(input logic [7:0] d);
        send_frame(d, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c0, delta;
        void'($urandom(32'd4711));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(3);

        // R1 reset state
        chk("R1 fill", fill, 0);
        chk("R1 flags", {data_ready, overrun, irq_trig, irq_timeout}, 0);
        chk("R1 head", head_now(), 0);

        // R7 R9 basic single mode; measure latency of one frame
        c0 = cyc;
        send8(8'hA5);
        delta = dr_rise - c0;
        chk("R7 single data", head_now(), 11'h0A5);
        chk("R7 data_ready", data_ready, 1);
        chk("R9 single trig", irq_trig, 1);

        // R8 pop on the completion edge keeps the new character
        c0 = cyc;
        fork
            send8(8'h5A);
            begin
                while (cyc != c0 + delta - 1) @(negedge clk);
                pop = 1'b1;
                @(negedge clk);
                pop = 1'b0;
            end
        join
        chk("R8 pop race data", rd_data, 8'h5A);
        chk("R8 pop race overrun", overrun, 0);
        chk("R8 pop race fill", fill, 1);

        // R8 status read on the completion edge: overrun wins
        c0 = cyc;
        fork
            send8(8'h11);
            begin
                while (cyc != c0 + delta - 1) @(negedge clk);
                lsr_rd = 1'b1;
                @(negedge clk);
                lsr_rd = 1'b0;
            end
        join
        chk("R8 set wins", overrun, 1);
        chk("R8 discarded", rd_data, 8'h5A);
        lsr_rd = 1'b1;
        @(negedge clk);
        lsr_rd = 1'b0;
        chk("R8 cleared", overrun, 0);
        do_pop();
        chk("R7 empty after pop", {data_ready, fill}, 0);

        // R2 mid-bit sampling with edges corrupted
        send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R2 glitched bits", head_now(), 11'h0C3);
        do_pop();
        // R2 short low pulse is a false start
        rxd = 1'b0;
        wait_cyc(4);
        rxd = 1'b1;
        wait_cyc(40);
        chk("R2 false start", fill, 0);

        // R3 five bits
        word_len = 2'd0;
        send_frame(8'hFF, 5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R3 five-bit", head_now(), 11'h01F);
        do_pop();
        // R4 seven bits even parity, bad parity bit
        word_len = 2'd2; par_en = 1'b1; par_even = 1'b1;
        send_frame(8'h35, 7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R4 even parity error", head_now(), exp_entry(8'h35, 7, 1, 1, 1));
        do_pop();
        par_even = 1'b0;
        send_frame(8'h35, 7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R4 odd parity ok", head_now(), exp_entry(8'h35, 7, 1, 0, 1));
        do_pop();

        // R5 framing error
        word_len = 2'd3; par_en = 1'b0;
        send_frame(8'h96, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 framing", head_now(), exp_entry(8'h96, 8, 0, 0, 0));
        chk("R2 no entry after low stop", fill, 1);
        do_pop();

        // R6 break
        rxd = 1'b0;
        wait_cyc(16 * 14);
        rxd = 1'b1;
        wait_cyc(100);
        chk("R6 break entry", head_now(), 11'h600);
        chk("R6 single entry", fill, 1);
        do_pop();

        // R9 trigger level 4 in queue mode, R7 order
        fifo_en = 1'b1; trig_sel = 2'd1;
        for (int i = 0; i < 3; i++) send8(8'h40 + 8'(i));
        chk("R9 below level", {irq_trig, fill}, {1'b0, 5'd3});
        send8(8'h43);
        chk("R9 at level", irq_trig, 1);
        chk("R7 head order", rd_data, 8'h40);
        do_pop();
        chk("R9 below again", irq_trig, 0);
        for (int i = 1; i < 4; i++) begin
            chk("R7 order", rd_data, 8'h40 + 8'(i));
            do_pop();
        end

        // R8 overrun in queue mode, R9 level 14
        trig_sel = 2'd3;
        for (int i = 0; i < 16; i++) send8(8'h80 + 8'(i));
        chk("R7 full", {fill, overrun}, {5'd16, 1'b0});
        chk("R9 level 14", irq_trig, 1);
        send8(8'hEE);
        chk("R8 queue overrun", {fill, overrun}, {5'd16, 1'b1});
        for (int i = 0; i < 16; i++) begin
            chk("R8 survivors", rd_data, 8'h80 + 8'(i));
            do_pop();
        end
        lsr_rd = 1'b1;
        @(negedge clk);
        lsr_rd = 1'b0;
        chk("R8 clear", overrun, 0);

        // R10 timeout after four 10-bit characters of 16 strobes
        send8(8'h3E);
        while (cyc < dr_rise + 630) @(negedge clk);
        chk("R10 before limit", irq_timeout, 0);
        while (cyc < dr_rise + 650) @(negedge clk);
        chk("R10 after limit", irq_timeout, 1);
        do_pop();
        chk("R10 clears on pop", irq_timeout, 0);

        // R11 no timeout in single mode
        fifo_en = 1'b0;
        send8(8'h3F);
        wait_cyc(1000);
        chk("R11 single mode", irq_timeout, 0);
        send8(8'h40);
        chk("R8 single overrun", overrun, 1);

        // R12 local reset
        word_len = 2'd2; par_en = 1'b1; par_even = 1'b0;
        rx_en = 1'b0;
        wait_cyc(3);
        chk("R12 cleared", {fill, overrun, data_ready}, 0);
        rx_en = 1'b1;
        rxd = 1'b0;
        wait_cyc(40);
        rx_en = 1'b0;
        rxd = 1'b1;
        wait_cyc(20);
        rx_en = 1'b1;
        wait_cyc(20);
        chk("R12 abort mid-frame", fill, 0);
        send_frame(8'h55, 7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R12 resume", head_now(), exp_entry(8'h55, 7, 1, 0, 1));
        do_pop();

        // random frames, R3 R4 R7
        fifo_en = 1'b1;
        for (int n = 0; n < 30; n++) begin
            logic [7:0] d;
            int nb;
            bit pe, pv, fl;
            tick_div = $urandom_range(3, 1);
            nb = 5 + $urandom_range(3, 0);
            pe = $urandom_range(1, 0) == 1;
            pv = $urandom_range(1, 0) == 1;
            fl = pe && ($urandom_range(3, 0) == 0);
            d = 8'($urandom);
            word_len = 2'(nb - 5); par_en = pe; par_even = pv;
            wait_cyc(2);
            send_frame(d, nb, pe, pv, fl, 1'b1, 1'b0);
            chk("R3 R4 random entry", head_now(), exp_entry(d, nb, pe, fl, 1));
            chk("R7 random fill", fill, 1);
            do_pop();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule